// File: doc/BRIEF.md
# Memory-Mapped Interrupt Aggregator

This block gathers a set of level-sensitive interrupt request lines into one sticky cause word and one enable word. A small memory-mapped register bus, with an address, a write strobe, write data and combinational read data, reaches both words. The block drives one registered interrupt line toward a parent interrupt controller. That line is high while any latched cause bit is also enabled. The block also presents the index of the pending, enabled source with the smallest bit number, so a handler can pick its next source without scanning the word.

A cause bit is set on every clock edge at which its request line is high. It stays set until software writes a one to that bit position. If a request is still active during such an acknowledge, the request wins, so a persisting level is never dropped. Software enables and disables sources by writing the whole enable word. To silence the block, software clears the enable word and then writes all ones to the cause word. A read-only status word combines a pending flag with the encoded index.

The register bus is a control path, not a data stream. It has no valid/ready pair and applies no back-pressure. Every write takes effect at the next clock edge, and every read returns data in the same cycle the address is presented.

Top module: `intr_aggregator`

## Requirements
- R1: After reset the cause word, the enable word, the interrupt output, the index output and the status word are all zero.
- R2: A request line that is high at a clock edge sets its cause bit (bit i for line i) at that edge. The bit then stays set after the line drops.
- R3: A write to offset 0x00 clears each cause bit whose written data bit is one. Cause bits written as zero are unchanged.
- R4: When a request line is high at the same edge as an acknowledge of its bit, the cause bit remains set.
- R5: A write to offset 0x04 replaces the whole enable word. Enable bit i equal to one enables line i. A read of 0x04 returns the current enable word, and a read of 0x00 returns the current cause word.
- R6: The interrupt output is registered. It equals, one edge later, whether (cause AND enable) is nonzero, so a latched but disabled cause never raises it.
- R7: The index output is registered alongside the interrupt output. It holds the smallest bit number set in (cause AND enable), covering positions 0 through 31, and it is zero when nothing is pending.
- R8: A read of offset 0x08 returns the pending flag in bit 31, zeros in bits 30 to 5, and the index in bits 4 to 0.
- R9: A read of any offset other than 0x00, 0x04 and 0x08 returns zero. A write to any such offset changes neither word.
- R10: Writing zero to the enable word and then all ones to the cause word, with all request lines low, leaves both words zero and the interrupt output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Level-sensitive request lines, one per source |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Combined interrupt toward the parent controller |
| pend_index_o | output | 5 | Lowest-numbered pending, enabled source |

## Verification
Cause and enable writes, and request lines, take effect at the next edge. Read data follows the current register contents in the same cycle. The interrupt line and the index trail a cause or enable change by exactly one more edge, so a request raises the interrupt two edges after the line is seen high. The bench drives every input half a period before an edge and keeps a cycle-accurate model of both words and of the registered outputs. Each expected item is queued with the model state that holds between the edges, and a monitor compares it two nanoseconds before the next rising edge. In this way every comparison lands in the cycle the latencies above predict.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam logic [7:0] OFF_CAUSE  = 8'h00;
  localparam logic [7:0] OFF_ENABLE = 8'h04;
  localparam logic [7:0] OFF_STATUS = 8'h08;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CAUSE,
    SEL_ENABLE,
    SEL_STATUS
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [7:0] off);
    case (off)
      OFF_CAUSE:  decode_offset = SEL_CAUSE;
      OFF_ENABLE: decode_offset = SEL_ENABLE;
      OFF_STATUS: decode_offset = SEL_STATUS;
      default:    decode_offset = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irqagg_cause.sv
module irqagg_cause #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_lines,
  input  logic               ack_en,
  input  logic [NUM_SRC-1:0] ack_bits,
  output logic [NUM_SRC-1:0] cause_q
);

  logic [NUM_SRC-1:0] kept;

  // Acknowledge clears first; live requests are ORed in afterwards so they win.
  always_comb begin
    kept = cause_q;
    if (ack_en) kept = cause_q & ~ack_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= kept | req_lines;
  end

endmodule

// File: rtl/irqagg_enable.sv
module irqagg_enable #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_word,
  output logic [NUM_SRC-1:0] enable_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     enable_q <= '0;
    else if (wr_en) enable_q <= wr_word;
  end

endmodule

// File: rtl/irqagg_prio.sv
module irqagg_prio #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic               any_pend,
  output logic [IDX_W-1:0]   first_idx
);

  logic [NUM_SRC-1:0] first_hot;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_first
      if (gi == 0) begin : g_lsb
        assign first_hot[gi] = pend[gi];
      end else begin : g_upper
        assign first_hot[gi] = pend[gi] & ~(|pend[gi-1:0]);
      end
    end
  endgenerate

  // first_hot is one-hot or zero, so ORing the positions encodes it.
  always_comb begin
    first_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (first_hot[i]) first_idx = first_idx | IDX_W'(i);
    end
  end

  assign any_pend = |pend;

endmodule

// File: rtl/irqagg_regread.sv
module irqagg_regread
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] cause_q,
  input  logic [NUM_SRC-1:0] enable_q,
  input  logic               pend_q,
  input  logic [IDX_W-1:0]   idx_q,
  output logic [NUM_SRC-1:0] rdata
);

  logic [NUM_SRC-1:0] status_word;

  assign status_word = {pend_q, {(NUM_SRC-1-IDX_W){1'b0}}, idx_q};

  always_comb begin
    unique case (sel)
      SEL_CAUSE:  rdata = cause_q;
      SEL_ENABLE: rdata = enable_q;
      SEL_STATUS: rdata = status_word;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_o,
  output logic [IDX_W-1:0]   pend_index_o
);

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] cause_q;
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] pending;
  logic               any_pend;
  logic [IDX_W-1:0]   first_idx;
  logic               irq_q;
  logic [IDX_W-1:0]   idx_q;

  assign sel = decode_offset(8'(bus_addr));

  irqagg_cause #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_lines(src_i),
    .ack_en   (bus_we && sel == SEL_CAUSE),
    .ack_bits (bus_wdata),
    .cause_q  (cause_q)
  );

  irqagg_enable #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we && sel == SEL_ENABLE),
    .wr_word (bus_wdata),
    .enable_q(enable_q)
  );

  assign pending = cause_q & enable_q;

  irqagg_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .pend     (pending),
    .any_pend (any_pend),
    .first_idx(first_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      idx_q <= '0;
    end else begin
      irq_q <= any_pend;
      idx_q <= first_idx;
    end
  end

  irqagg_regread #(.NUM_SRC(NUM_SRC)) u_read (
    .sel     (sel),
    .cause_q (cause_q),
    .enable_q(enable_q),
    .pend_q  (irq_q),
    .idx_q   (idx_q),
    .rdata   (bus_rdata)
  );

  assign irq_o        = irq_q;
  assign pend_index_o = idx_q;

endmodule

// File: rtl/intr_aggregator_chk.sv
module intr_aggregator_chk #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] bus_rdata,
  input logic               irq_o,
  input logic [IDX_W-1:0]   pend_index_o,
  input logic [NUM_SRC-1:0] cause_q,
  input logic [NUM_SRC-1:0] enable_q
);

  logic               at_cause;
  logic               at_enable;
  logic               unmapped;
  logic [NUM_SRC-1:0] below_idx;

  assign at_cause  = (bus_addr == ADDR_W'(0));
  assign at_enable = (bus_addr == ADDR_W'(4));
  assign unmapped  = !at_cause && !at_enable && (bus_addr != ADDR_W'(8));
  assign below_idx = (NUM_SRC'(1) << pend_index_o) - NUM_SRC'(1);

  assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(src_i)) == $past(src_i)));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && at_cause) |=> ((cause_q & $past(bus_wdata) & ~$past(src_i)) == '0));

  assert_no_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && at_cause) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  assert_enable_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && at_enable) |=> (enable_q == $past(bus_wdata)));

  assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && at_enable) |=> $stable(enable_q));

  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == ($past(cause_q & enable_q) != '0)));

  assert_index_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (((($past(cause_q & enable_q) >> pend_index_o) & NUM_SRC'(1)) != '0)
               && (($past(cause_q & enable_q) & below_idx) == '0)));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (bus_rdata == '0));

endmodule

bind intr_aggregator intr_aggregator_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_i       (src_i),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq_o       (irq_o),
  .pend_index_o(pend_index_o),
  .cause_q     (cause_q),
  .enable_q    (enable_q)
);

// File: tb/intr_aggregator_test.sv
`timescale 1ns/1ps
module intr_aggregator_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [4:0]  pend_index_o;

  always #4 clk = ~clk;

  intr_aggregator uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .pend_index_o(pend_index_o)
  );

  typedef struct {
    logic        chk_rd;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [4:0]  exp_idx;
    string       req;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit wd_hit = 0;

  // model state between edges
  logic [31:0] m_cause = '0;
  logic [31:0] m_en = '0;
  logic        m_irq = 1'b0;
  logic [4:0]  m_idx = '0;

  function automatic logic [4:0] lowest(input logic [31:0] v);
    lowest = '0;
    for (int i = 31; i >= 0; i--) if (v[i]) lowest = 5'(i);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00:   m_read = m_cause;
      8'h04:   m_read = m_en;
      8'h08:   m_read = {m_irq, 26'b0, m_idx};
      default: m_read = '0;
    endcase
  endfunction

  // one bus/request cycle; queues what must be seen before the next edge
  task automatic cyc(input logic [31:0] s, input logic we, input logic [7:0] a,
                     input logic [31:0] d, input logic rd, input string req);
    item_t it;
    logic [31:0] nc;
    @(negedge clk);
    src_i = s; bus_we = we; bus_addr = a; bus_wdata = d;
    it.chk_rd = rd; it.exp_rd = m_read(a); it.exp_irq = m_irq;
    it.exp_idx = m_idx; it.req = req;
    q.push_back(it);
    nc = m_cause;
    if (we && a == 8'h00) nc = nc & ~d;
    nc = nc | s;
    m_irq = (m_cause & m_en) != 0;
    m_idx = lowest(m_cause & m_en);
    if (we && a == 8'h04) m_en = d;
    m_cause = nc;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (irq_o !== it.exp_irq || pend_index_o !== it.exp_idx ||
            (it.chk_rd && bus_rdata !== it.exp_rd)) begin
          bad++;
          $display("FAIL %s: irq=%0b idx=%0d rd=%h expected irq=%0b idx=%0d rd=%h",
                   it.req, irq_o, pend_index_o, bus_rdata,
                   it.exp_irq, it.exp_idx, it.exp_rd);
        end
      end
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc(0, 0, 8'h00, 0, 1, "R1");
    cyc(0, 0, 8'h04, 0, 1, "R1");
    cyc(0, 0, 8'h08, 0, 1, "R1");
    // R2 pulse latches, stays after drop; disabled so no irq (R6)
    cyc(32'h8, 0, 8'h00, 0, 1, "R2");
    cyc(0, 0, 8'h00, 0, 1, "R2");
    cyc(0, 0, 8'h00, 0, 1, "R2");
    cyc(0, 0, 8'h08, 0, 1, "R6");
    // R5 enable write and readback
    cyc(0, 1, 8'h04, 32'h0000_0418, 1, "R5");
    cyc(0, 0, 8'h04, 0, 1, "R5");
    cyc(0, 0, 8'h08, 0, 1, "R6");
    // R7 multiple pending, lowest wins
    cyc(32'h0000_0410, 0, 8'h00, 0, 1, "R7");
    cyc(0, 0, 8'h08, 0, 1, "R7");
    cyc(0, 0, 8'h08, 0, 1, "R8");
    // R3 acknowledge bit 3, others untouched
    cyc(0, 1, 8'h00, 32'h8, 1, "R3");
    cyc(0, 0, 8'h00, 0, 1, "R3");
    cyc(0, 0, 8'h08, 0, 1, "R7");
    // R4 request held during ack of its bit
    cyc(32'h10, 1, 8'h00, 32'h10, 1, "R4");
    cyc(0, 0, 8'h00, 0, 1, "R4");
    cyc(0, 1, 8'h00, 32'h10, 1, "R3");
    cyc(0, 0, 8'h08, 0, 1, "R8");
    // R9 unmapped offsets
    cyc(0, 0, 8'h0C, 0, 1, "R9");
    cyc(0, 1, 8'h0C, 32'hFFFF_FFFF, 1, "R9");
    cyc(0, 1, 8'h40, 32'hFFFF_FFFF, 1, "R9");
    cyc(0, 0, 8'h00, 0, 1, "R9");
    cyc(0, 0, 8'h04, 0, 1, "R9");
    // R7 boundary bits 0 and 31
    cyc(0, 1, 8'h04, 32'hFFFF_FFFF, 1, "R5");
    cyc(32'h8000_0001, 0, 8'h08, 0, 1, "R7");
    cyc(0, 0, 8'h08, 0, 1, "R7");
    cyc(0, 1, 8'h00, 32'h0000_0401, 1, "R7");
    cyc(0, 0, 8'h08, 0, 1, "R8");
    cyc(0, 0, 8'h08, 0, 1, "R7");
    // R6 disabling drops irq a cycle later
    cyc(0, 1, 8'h04, 32'h0000_0001, 1, "R6");
    cyc(0, 0, 8'h08, 0, 1, "R6");
    cyc(0, 0, 8'h08, 0, 1, "R6");
    // R10 quiesce
    cyc(32'h0F0F_0000, 1, 8'h04, 32'hFFFF_FFFF, 1, "R10");
    cyc(0, 0, 8'h00, 0, 1, "R10");
    cyc(0, 1, 8'h04, 0, 1, "R10");
    cyc(0, 1, 8'h00, 32'hFFFF_FFFF, 1, "R10");
    cyc(0, 0, 8'h00, 0, 1, "R10");
    cyc(0, 0, 8'h04, 0, 1, "R10");
    cyc(0, 0, 8'h08, 0, 1, "R10");
    cyc(0, 0, 8'h08, 0, 1, "R10");
  endtask

  initial begin : main
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    disable fork;
    repeat (2) @(negedge clk);
    if (wd_hit) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule